// File: doc/BRIEF.md
# Clock-Crossing Memory-Mapped Register Bridge

This block lets a processor on a 32-bit memory-mapped slave port in one clock domain reach a simple register port running on an unrelated user clock. Each bus write or read is captured on the bus side and carried across as a request toggle through a two-flop synchroniser. On the register side it becomes either a one-cycle write strobe or a one-cycle read request. Completion returns the same way as an acknowledge toggle, and only then does the bus side release its wait request.

The register port is RAM-like. The address is shared by writes and reads and counts 32-bit words. A write carries 32 data bits and a 4-bit byte enable. A read may take any number of user cycles: the target answers with a read-valid strobe and the data. Only one transaction is ever in flight. The wait request stays high by default and drops for a single bus cycle when a transaction finishes. For a read, the returned word is presented on the bus in that same cycle.

Top module: `mm_reg_bridge`

## Requirements
- R1: While either reset is held and right after it, `bus_waitreq_o` is 1 and `reg_wr_o` and `reg_rd_o` are 0.
- R2: `bus_waitreq_o` is 1 except for exactly one CPU cycle per accepted transaction. That cycle ends the transaction. With no request present it never goes low.
- R3: A bus write (`bus_write_i`=1) produces exactly one `reg_wr_o` pulse, one user cycle long. During the pulse `reg_addr_o`, `reg_wdata_o` and `reg_be_o` equal the bus address, data and byte enable as presented. Byte-enable bit n qualifies data bits 8n+7 down to 8n.
- R4: A bus read (`bus_read_i`=1) produces exactly one `reg_rd_o` pulse, one user cycle long. `reg_addr_o` equals the bus address and stays unchanged until `reg_rvalid_i` is seen.
- R5: The word on `reg_rdata_i` in the cycle `reg_rvalid_i` is accepted appears on `bus_rdata_o` in the cycle `bus_waitreq_o` is 0. Any read latency from zero user cycles upward is accepted.
- R6: `reg_rvalid_i` is ignored when no read is pending. It releases no wait request and does not disturb the data of a later read.
- R7: A new request is taken only after the previous one has completed. Each bus transaction causes exactly one register-side strobe of its own kind, and write and read strobes never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Bus-side clock |
| cpu_rst_ni | input | 1 | Bus-side asynchronous reset, active low |
| bus_addr_i | input | AW | Word address from the bus master |
| bus_write_i | input | 1 | Write request |
| bus_read_i | input | 1 | Read request |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Write byte enables |
| bus_waitreq_o | output | 1 | Wait request; low for one cycle at completion |
| bus_rdata_o | output | 32 | Read data, valid while wait request is low after a read |
| usr_clk_i | input | 1 | Register-side clock |
| usr_rst_ni | input | 1 | Register-side asynchronous reset, active low |
| reg_addr_o | output | AW | Shared register word address |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 32 | Register write data |
| reg_be_o | output | 4 | Register write byte enables |
| reg_rd_o | output | 1 | One-cycle read request |
| reg_rvalid_i | input | 1 | Read data valid from the target |
| reg_rdata_i | input | 32 | Read data from the target |

## Verification
A request toggled on a CPU edge reaches the register side as a strobe on the third user edge: two synchroniser flops, then the detect register. The acknowledge, toggled one user edge after the strobe or the accepted read-valid, drops the wait request on the third CPU edge after it. Because the two clocks are unrelated, these counts give no fixed CPU cycle to sample at. The bench therefore samples every output at the falling edge of its own clock and waits on the wait request rather than on a cycle count. It checks that the low phase lasts exactly one cycle and that register strobes and held addresses match what the bench's own register model predicts.

// File: rtl/mmbr_pkg.sv
package mmbr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_N = WORD_W / 8;
  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;
endpackage

// File: rtl/mmbr_sync.sv
module mmbr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/mmbr_cpu_port.sv
module mmbr_cpu_port
  import mmbr_pkg::*;
#(
  parameter int unsigned AW   = 12,
  parameter int unsigned SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              write_i,
  input  logic              read_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BYTE_N-1:0] be_i,
  output logic              waitreq_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              req_tgl_o,
  output op_e               op_o,
  output logic [AW-1:0]     addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [BYTE_N-1:0] be_o,
  input  logic              ack_tgl_i,
  input  logic [WORD_W-1:0] xrdata_i
);
  logic              busy_q, done_q, ack_seen_q, req_q;
  logic              ack_s, ack_new, start;
  op_e               op_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [BYTE_N-1:0] be_q;

  mmbr_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl_i),
    .q_o   (ack_s)
  );

  assign ack_new = busy_q && (ack_s != ack_seen_q);
  // the completing request is still on the bus during done_q; do not restart on it
  assign start   = !busy_q && !done_q && (write_i || read_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      ack_seen_q <= 1'b0;
      req_q      <= 1'b0;
      op_q       <= OP_WRITE;
      addr_q     <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      rdata_q    <= '0;
    end else begin
      done_q <= ack_new;
      if (start) begin
        busy_q  <= 1'b1;
        req_q   <= ~req_q;
        op_q    <= read_i ? OP_READ : OP_WRITE;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
      if (ack_new) begin
        busy_q     <= 1'b0;
        ack_seen_q <= ack_s;
        if (op_q == OP_READ) rdata_q <= xrdata_i;
      end
    end
  end

  assign waitreq_o = !done_q;
  assign rdata_o   = rdata_q;
  assign req_tgl_o = req_q;
  assign op_o      = op_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign be_o      = be_q;

  // R2
  wait_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !waitreq_o |=> waitreq_o);

  // R7
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_new) |=> $stable({addr_q, wdata_q, be_q, op_q}));
endmodule

// File: rtl/mmbr_usr_port.sv
module mmbr_usr_port
  import mmbr_pkg::*;
#(
  parameter int unsigned AW   = 12,
  parameter int unsigned SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  op_e               op_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BYTE_N-1:0] be_i,
  output logic              ack_tgl_o,
  output logic [WORD_W-1:0] xrdata_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic              reg_wr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic [BYTE_N-1:0] reg_be_o,
  output logic              reg_rd_o,
  input  logic              reg_rvalid_i,
  input  logic [WORD_W-1:0] reg_rdata_i
);
  logic              req_s, req_seen_q, req_new;
  logic              wr_q, rd_q, pend_q, got_q, ack_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [BYTE_N-1:0] be_q;

  mmbr_sync #(.STAGES(SYNC)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_i),
    .q_o   (req_s)
  );

  assign req_new = req_s != req_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_seen_q <= 1'b0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      pend_q     <= 1'b0;
      got_q      <= 1'b0;
      ack_q      <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      rdata_q    <= '0;
    end else begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      got_q <= pend_q && reg_rvalid_i;
      // data is registered one cycle before the acknowledge toggles
      ack_q <= ack_q ^ (wr_q | got_q);
      if (pend_q && reg_rvalid_i) begin
        pend_q  <= 1'b0;
        rdata_q <= reg_rdata_i;
      end
      if (req_new) begin
        req_seen_q <= req_s;
        addr_q     <= addr_i;
        if (op_i == OP_READ) begin
          rd_q   <= 1'b1;
          pend_q <= 1'b1;
        end else begin
          wr_q    <= 1'b1;
          wdata_q <= wdata_i;
          be_q    <= be_i;
        end
      end
    end
  end

  assign ack_tgl_o   = ack_q;
  assign xrdata_o    = rdata_q;
  assign reg_addr_o  = addr_q;
  assign reg_wr_o    = wr_q;
  assign reg_rd_o    = rd_q;
  assign reg_wdata_o = wdata_q;
  assign reg_be_o    = be_q;

  // R3
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  // R4
  rd_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !reg_rvalid_i) |=> $stable(reg_addr_o));

  // R7
  one_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_wr_o, reg_rd_o}));

  // R7
  no_req_while_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !req_new);

  // R6
  stray_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !wr_q && !got_q) |=> $stable(ack_q));
endmodule

// File: rtl/mm_reg_bridge.sv
module mm_reg_bridge
  import mmbr_pkg::*;
#(
  parameter int unsigned AW   = 12,
  parameter int unsigned SYNC = 2
) (
  input  logic              cpu_clk_i,
  input  logic              cpu_rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_write_i,
  input  logic              bus_read_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  input  logic [BYTE_N-1:0] bus_be_i,
  output logic              bus_waitreq_o,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              usr_clk_i,
  input  logic              usr_rst_ni,
  output logic [AW-1:0]     reg_addr_o,
  output logic              reg_wr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic [BYTE_N-1:0] reg_be_o,
  output logic              reg_rd_o,
  input  logic              reg_rvalid_i,
  input  logic [WORD_W-1:0] reg_rdata_i
);
  logic              req_tgl, ack_tgl;
  op_e               x_op;
  logic [AW-1:0]     x_addr;
  logic [WORD_W-1:0] x_wdata, x_rdata;
  logic [BYTE_N-1:0] x_be;

  mmbr_cpu_port #(.AW(AW), .SYNC(SYNC)) u_cpu (
    .clk_i    (cpu_clk_i),
    .rst_ni   (cpu_rst_ni),
    .addr_i   (bus_addr_i),
    .write_i  (bus_write_i),
    .read_i   (bus_read_i),
    .wdata_i  (bus_wdata_i),
    .be_i     (bus_be_i),
    .waitreq_o(bus_waitreq_o),
    .rdata_o  (bus_rdata_o),
    .req_tgl_o(req_tgl),
    .op_o     (x_op),
    .addr_o   (x_addr),
    .wdata_o  (x_wdata),
    .be_o     (x_be),
    .ack_tgl_i(ack_tgl),
    .xrdata_i (x_rdata)
  );

  mmbr_usr_port #(.AW(AW), .SYNC(SYNC)) u_usr (
    .clk_i       (usr_clk_i),
    .rst_ni      (usr_rst_ni),
    .req_tgl_i   (req_tgl),
    .op_i        (x_op),
    .addr_i      (x_addr),
    .wdata_i     (x_wdata),
    .be_i        (x_be),
    .ack_tgl_o   (ack_tgl),
    .xrdata_o    (x_rdata),
    .reg_addr_o  (reg_addr_o),
    .reg_wr_o    (reg_wr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_be_o    (reg_be_o),
    .reg_rd_o    (reg_rd_o),
    .reg_rvalid_i(reg_rvalid_i),
    .reg_rdata_i (reg_rdata_i)
  );
endmodule

// File: tb/sim_mm_reg_bridge.sv
`timescale 1ns/100ps
module sim_mm_reg_bridge;
  localparam int AW = 12;

  logic          cpu_clk = 1'b0, usr_clk = 1'b0;
  logic          cpu_rst_n = 1'b0, usr_rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_write = 1'b0, bus_read = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_be = '0;
  logic          bus_waitreq;
  logic [31:0]   bus_rdata;
  logic [AW-1:0] reg_addr;
  logic          reg_wr, reg_rd;
  logic [31:0]   reg_wdata;
  logic [3:0]    reg_be;
  logic          reg_rvalid = 1'b0;
  logic [31:0]   reg_rdata = 32'hDEAD_BEEF;

  always #10  cpu_clk = ~cpu_clk;
  always #6.5 usr_clk = ~usr_clk;

  mm_reg_bridge #(.AW(AW)) u0 (
    .cpu_clk_i(cpu_clk), .cpu_rst_ni(cpu_rst_n),
    .bus_addr_i(bus_addr), .bus_write_i(bus_write), .bus_read_i(bus_read),
    .bus_wdata_i(bus_wdata), .bus_be_i(bus_be),
    .bus_waitreq_o(bus_waitreq), .bus_rdata_o(bus_rdata),
    .usr_clk_i(usr_clk), .usr_rst_ni(usr_rst_n),
    .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .reg_be_o(reg_be), .reg_rd_o(reg_rd),
    .reg_rvalid_i(reg_rvalid), .reg_rdata_i(reg_rdata)
  );

  int n_tests = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [AW-1:0] last_addr;
  logic [31:0]   last_wdata;
  logic [3:0]    last_be;
  logic [31:0]   tgt_mem [16];
  logic [31:0]   exp_mem [16];
  int            force_lat = -1;
  bit            stray_req = 1'b0;

  function automatic logic [31:0] merge(logic [31:0] old_w, logic [31:0] new_w, logic [3:0] be);
    logic [31:0] r = old_w;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
    return r;
  endfunction

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // register target model, sampled away from the user clock edge
  initial begin
    for (int i = 0; i < 16; i++) tgt_mem[i] = 32'h0;
    forever begin
      @(negedge usr_clk);
      if (reg_wr) begin
        wr_cnt++;
        last_addr  = reg_addr;
        last_wdata = reg_wdata;
        last_be    = reg_be;
        tgt_mem[reg_addr[3:0]] = merge(tgt_mem[reg_addr[3:0]], reg_wdata, reg_be);
      end else if (reg_rd) begin
        logic [AW-1:0] a;
        int lat;
        rd_cnt++;
        a = reg_addr;
        last_addr = reg_addr;
        lat = (force_lat >= 0) ? force_lat : int'($urandom % 7);
        for (int k = 0; k < lat; k++) begin
          @(negedge usr_clk);
          // R4: address held while the read is outstanding
          if (reg_addr != a) check(1'b0, "R4", 32'(reg_addr), 32'(a));
        end
        reg_rvalid = 1'b1;
        reg_rdata  = tgt_mem[a[3:0]];
        @(negedge usr_clk);
        reg_rvalid = 1'b0;
        reg_rdata  = 32'hDEAD_BEEF;
      end else if (stray_req) begin
        reg_rvalid = 1'b1;
        reg_rdata  = 32'hBAD0_BAD0;
        @(negedge usr_clk);
        reg_rvalid = 1'b0;
        reg_rdata  = 32'hDEAD_BEEF;
        stray_req  = 1'b0;
      end
    end
  end

  task automatic finish_bus(output int low_cycles, output logic [31:0] rd);
    do @(negedge cpu_clk); while (bus_waitreq);
    rd = bus_rdata;
    @(negedge cpu_clk);
    bus_write = 1'b0;
    bus_read  = 1'b0;
    low_cycles = bus_waitreq ? 1 : 2;
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be);
    int lc, w0, r0;
    logic [31:0] unused;
    w0 = wr_cnt; r0 = rd_cnt;
    bus_addr = a; bus_wdata = d; bus_be = be; bus_write = 1'b1;
    finish_bus(lc, unused);
    exp_mem[a[3:0]] = merge(exp_mem[a[3:0]], d, be);
    check(lc == 1, "R2", 32'(lc), 32'd1);
    check(wr_cnt == w0 + 1 && rd_cnt == r0, "R7", 32'(wr_cnt - w0), 32'd1);
    check(last_addr == a && last_wdata == d && last_be == be, "R3",
          last_wdata, d);
  endtask

  task automatic bus_rd(logic [AW-1:0] a);
    int lc, w0, r0;
    logic [31:0] got;
    w0 = wr_cnt; r0 = rd_cnt;
    bus_addr = a; bus_read = 1'b1;
    finish_bus(lc, got);
    check(lc == 1, "R2", 32'(lc), 32'd1);
    check(rd_cnt == r0 + 1 && wr_cnt == w0, "R7", 32'(rd_cnt - r0), 32'd1);
    check(last_addr == a, "R4", 32'(last_addr), 32'(a));
    check(got == exp_mem[a[3:0]], "R5", got, exp_mem[a[3:0]]);
  endtask

  initial begin
    bit low_seen;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) exp_mem[i] = 32'h0;
    #3;
    // R1: state during reset
    check(bus_waitreq == 1'b1 && !reg_wr && !reg_rd, "R1", 32'(bus_waitreq), 32'd1);
    #97;
    @(negedge cpu_clk); cpu_rst_n = 1'b1;
    @(negedge usr_clk); usr_rst_n = 1'b1;
    @(negedge cpu_clk);
    check(bus_waitreq == 1'b1 && !reg_wr && !reg_rd, "R1", 32'(bus_waitreq), 32'd1);

    // R2: idle bus never releases wait request
    low_seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge cpu_clk);
      if (!bus_waitreq) low_seen = 1'b1;
    end
    check(!low_seen && wr_cnt == 0 && rd_cnt == 0, "R2", 32'(low_seen), 32'd0);

    // directed corners
    force_lat = 0;
    bus_wr(12'h000, 32'h1122_3344, 4'hF);
    bus_rd(12'h000);
    bus_wr(12'h000, 32'hAABB_CCDD, 4'b0101);   // R3 partial enables
    bus_rd(12'h000);
    bus_wr(12'h000, 32'hFFFF_FFFF, 4'b0000);   // R3 no bytes enabled
    bus_rd(12'h000);
    bus_wr(12'hFFF, 32'hCAFE_F00D, 4'hF);      // top address
    force_lat = 25;                            // R4 long read latency
    bus_rd(12'hFFF);
    force_lat = -1;

    // R6: stray read-valid while idle
    stray_req = 1'b1;
    low_seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge cpu_clk);
      if (!bus_waitreq) low_seen = 1'b1;
    end
    check(!low_seen, "R6", 32'(low_seen), 32'd0);
    bus_rd(12'hFFF);
    check(bus_rdata == 32'hCAFE_F00D, "R6", bus_rdata, 32'hCAFE_F00D);

    // random mix, back to back
    for (int n = 0; n < 80; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if ($urandom % 2) bus_wr(a, $urandom, 4'($urandom));
      else              bus_rd(a);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge cpu_clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule